// File: doc/BRIEF.md
# SCL Clock Divider

This block paces the SCL line of an I2C master from a fast peripheral clock. A small pre-divider turns the peripheral clock into an internal tick. A phase counter then counts those ticks through one SCL period. The period length is a fixed base of 20 ticks, plus 8 ticks for each step of a 6-bit gear value, plus a latency count. The latency count stands for the time the bus needs for its edges to rise and fall and for the internal path delay, about 285 ns in total, rounded up to whole ticks.

Each period is split into a low phase and a high phase. The low phase is the lower half of the tick count; the high phase takes the remaining ticks. The byte engine uses the phase strobes to place its SDA changes and its sampling. During the high phase a target may hold the line low, and the phase counter waits while it does. A new configuration word is held aside and applied only at a period boundary. As a result, no SCL pulse is ever cut short.

Top module: `scl_clk_gen`

## Requirements
- R1: After reset, scl_low_o, fall_stb_o, rise_stb_o and ick_tick_o are all 0, and the active configuration is gear 0, pre-divide 0, latency 0.
- R2: The configuration word is decoded as follows. The pre-divide value `d` is bits [P-1:0], and the gear `g` is bits [P+5:P]. P is 3 when WIDE_PREDIV=1 (the default) and 2 when WIDE_PREDIV=0.
- R3: While the clock is running and not paused, ick_tick_o pulses once every d+1 peripheral clock cycles.
- R4: With N = 20 + 8*g + L (L being the latency count), the low phase lasts floor(N/2)*(d+1) cycles. Without stretching, the high phase lasts (N - floor(N/2))*(d+1) cycles.
- R5: When run_i is first seen high while idle, scl_low_o and fall_stb_o are 1 in the next cycle. fall_stb_o is 1 only in the first cycle of each low phase, and rise_stb_o is 1 only in the first cycle of each high phase.
- R6: During the high phase, each cycle with scl_sense_i = 0 freezes the count. Holding scl_sense_i low for K cycles makes that high phase exactly K cycles longer.
- R7: scl_sense_i has no effect during the low phase: the low phase length is unchanged when scl_sense_i is held low throughout it.
- R8: A configuration write that lands inside a period leaves that period at its old length. The new values take effect from the next period. If several writes land before the boundary, the last one is used.
- R9: When run_i drops, scl_low_o is 0 from the next cycle on, and no strobe or tick is produced while run_i stays low. A restart uses any configuration written while idle.
- R10: lat_i is sampled only at period boundaries. A change in the middle of a period first alters the length of the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Level: 1 keeps SCL toggling, 0 returns to idle |
| cfg_wr_i | input | 1 | One-cycle strobe that writes cfg_word_i into the pending register |
| cfg_word_i | input | 6+P | Gear above pre-divide (P = 3 or 2) |
| lat_i | input | LAT_W | Edge/delay compensation count in ticks |
| scl_sense_i | input | 1 | Synchronized level of the SCL wire |
| scl_low_o | output | 1 | 1 while the master pulls SCL low |
| fall_stb_o | output | 1 | First cycle of a low phase |
| rise_stb_o | output | 1 | First cycle of a high phase |
| ick_tick_o | output | 1 | Internal clock enable pulse |

## Verification
The assertions assume two things about the inputs. First, scl_sense_i is already synchronous to clk. Second, run_i is a level that changes between edges, so the phase counter never sees a partial cycle. The stimulus meets both assumptions: it drives every input on the falling clock edge. It places configuration and latency changes one cycle after a low-phase start, never in the boundary cycle itself. Stretch pulses are only applied after a rise strobe has been seen, so they fall inside a high phase by construction.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int GEAR_W     = 6;
    localparam int PDIV_MAX_W = 3;
    localparam int LAT_MAX_W  = 5;
    localparam int BASE_TICKS = 20;
    localparam int GEAR_SHIFT = 3;   // 8 ticks per gear step
    localparam int MAX_TICKS  = BASE_TICKS + ((2**GEAR_W - 1) << GEAR_SHIFT) + (2**LAT_MAX_W - 1);
    localparam int CNT_W      = $clog2(MAX_TICKS + 1);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    typedef struct packed {
        logic [GEAR_W-1:0]     gear;
        logic [PDIV_MAX_W-1:0] pdiv;
        logic [LAT_MAX_W-1:0]  lat;
    } scl_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] low_len;
        logic [CNT_W-1:0] high_len;
    } scl_split_t;

    function automatic logic [CNT_W-1:0] period_ticks(input scl_cfg_t c);
        return CNT_W'(BASE_TICKS) + (CNT_W'(c.gear) << GEAR_SHIFT) + CNT_W'(c.lat);
    endfunction

    function automatic scl_split_t split_period(input scl_cfg_t c);
        scl_split_t s;
        logic [CNT_W-1:0] n;
        n          = period_ticks(c);
        s.low_len  = n >> 1;
        s.high_len = n - (n >> 1);
        return s;
    endfunction

endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg
    import scl_div_pkg::*;
#(
    parameter int PDIV_W = 3,
    parameter int LAT_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_i,
    input  logic [GEAR_W+PDIV_W-1:0] word_i,
    input  logic [LAT_W-1:0]         lat_i,
    input  logic                     load_i,
    output scl_cfg_t                 act_o
);

    logic [PDIV_MAX_W-1:0] pdiv_dec;
    logic [GEAR_W-1:0]     gear_dec;

    assign gear_dec = word_i[PDIV_W +: GEAR_W];

    generate
        if (PDIV_W < PDIV_MAX_W) begin : g_narrow
            assign pdiv_dec = {{(PDIV_MAX_W-PDIV_W){1'b0}}, word_i[PDIV_W-1:0]};
        end else begin : g_wide
            assign pdiv_dec = word_i[PDIV_MAX_W-1:0];
        end
    endgenerate

    scl_cfg_t pend_q;
    logic     pend_v_q;
    scl_cfg_t act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            act_q    <= '0;
        end else begin
            if (wr_i) begin
                pend_q.gear <= gear_dec;
                pend_q.pdiv <= pdiv_dec;
                pend_q.lat  <= '0;
            end
            if (load_i) begin
                if (pend_v_q) begin
                    act_q.gear <= pend_q.gear;
                    act_q.pdiv <= pend_q.pdiv;
                end
                act_q.lat <= LAT_MAX_W'(lat_i);
                pend_v_q  <= wr_i;
            end else if (wr_i) begin
                pend_v_q <= 1'b1;
            end
        end
    end

    assign act_o = act_q;

    // R8 / R10: active settings move only on a period boundary
    a_r8_hold_between_bounds: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(act_q));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
    import scl_div_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr_i,
    input  logic                  en_i,
    input  logic [PDIV_MAX_W-1:0] div_i,
    output logic                  tick_o
);

    logic [PDIV_MAX_W-1:0] pcnt_q;

    assign tick_o = en_i && (pcnt_q == div_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pcnt_q <= '0;
        end else if (tick_o) begin
            pcnt_q <= '0;
        end else if (en_i) begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // R3: count never passes the programmed divide value
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
        pcnt_q <= div_i);

    // R3: with a divide above zero two ticks are never adjacent
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             sense_i,
    input  scl_split_t       split_i,
    output scl_phase_e       phase_o,
    output logic             load_o,
    output logic             presc_en_o,
    output logic             presc_clr_o,
    output logic             fall_o,
    output logic             rise_o
);

    scl_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fall_q;
    logic             rise_q;
    logic             low_end;
    logic             high_end;

    assign low_end  = (phase_q == PH_LOW)  && tick_i && (cnt_q == split_i.low_len - 1'b1);
    assign high_end = (phase_q == PH_HIGH) && tick_i && (cnt_q == split_i.high_len - 1'b1);

    assign load_o      = run_i && ((phase_q == PH_IDLE) || high_end);
    assign presc_clr_o = (phase_q == PH_IDLE);
    assign presc_en_o  = (phase_q == PH_LOW) || ((phase_q == PH_HIGH) && sense_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            fall_q  <= 1'b0;
            rise_q  <= 1'b0;
        end else begin
            fall_q <= load_o;
            rise_q <= run_i && low_end;
            if (!run_i) begin
                phase_q <= PH_IDLE;
                cnt_q   <= '0;
            end else begin
                unique case (phase_q)
                    PH_IDLE: begin
                        phase_q <= PH_LOW;
                        cnt_q   <= '0;
                    end
                    PH_LOW: begin
                        if (low_end) begin
                            phase_q <= PH_HIGH;
                            cnt_q   <= '0;
                        end else if (tick_i) begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_HIGH: begin
                        if (high_end) begin
                            phase_q <= PH_LOW;
                            cnt_q   <= '0;
                        end else if (tick_i) begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end
                endcase
            end
        end
    end

    assign phase_o = phase_q;
    assign fall_o  = fall_q;
    assign rise_o  = rise_q;

    // R4: counters stay inside the half they belong to
    a_r4_low_range: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOW) |-> (cnt_q < split_i.low_len));
    a_r4_high_range: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HIGH) |-> (cnt_q < split_i.high_len));

    // R6: a held-low line freezes the high-phase count
    a_r6_stretch_hold: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HIGH && !sense_i && run_i) |=> ($stable(cnt_q) && phase_q == PH_HIGH));

    // R9: dropping run returns to idle in one cycle
    a_r9_idle_on_stop: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen
    import scl_div_pkg::*;
#(
    parameter bit WIDE_PREDIV = 1'b1,
    parameter int LAT_W       = 4,
    localparam int PDIV_W     = WIDE_PREDIV ? 3 : 2,
    localparam int WORD_W     = GEAR_W + PDIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              cfg_wr_i,
    input  logic [WORD_W-1:0] cfg_word_i,
    input  logic [LAT_W-1:0]  lat_i,
    input  logic              scl_sense_i,
    output logic              scl_low_o,
    output logic              fall_stb_o,
    output logic              rise_stb_o,
    output logic              ick_tick_o
);

    scl_cfg_t   act_cfg;
    scl_split_t split;
    scl_phase_e phase;
    logic       load;
    logic       presc_en;
    logic       presc_clr;
    logic       tick;

    assign split = split_period(act_cfg);

    scl_cfg_reg #(
        .PDIV_W (PDIV_W),
        .LAT_W  (LAT_W)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (cfg_wr_i),
        .word_i (cfg_word_i),
        .lat_i  (lat_i),
        .load_i (load),
        .act_o  (act_cfg)
    );

    scl_prescaler u_presc (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (presc_clr),
        .en_i   (presc_en),
        .div_i  (act_cfg.pdiv),
        .tick_o (tick)
    );

    scl_phase_ctr u_phase (
        .clk         (clk),
        .rst         (rst),
        .run_i       (run_i),
        .tick_i      (tick),
        .sense_i     (scl_sense_i),
        .split_i     (split),
        .phase_o     (phase),
        .load_o      (load),
        .presc_en_o  (presc_en),
        .presc_clr_o (presc_clr),
        .fall_o      (fall_stb_o),
        .rise_o      (rise_stb_o)
    );

    assign scl_low_o  = (phase == PH_LOW);
    assign ick_tick_o = tick;

    // R5: the two edge strobes never coincide
    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fall_stb_o, rise_stb_o}));

    // R5: a fall strobe always marks a cycle where SCL is driven low
    a_r5_fall_in_low: assert property (@(posedge clk) disable iff (rst)
        fall_stb_o |-> scl_low_o);

    // R5: a rise strobe always marks a released cycle
    a_r5_rise_in_high: assert property (@(posedge clk) disable iff (rst)
        rise_stb_o |-> !scl_low_o);

endmodule

// File: tb/sim_scl_clk_gen.sv
module sim_scl_clk_gen;

    localparam int PW = 3;
    localparam int WW = 6 + PW;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [WW-1:0] cfg_word = '0;
    logic [LW-1:0] lat = '0;
    logic          sense = 1'b1;
    logic          scl_low, fall_stb, rise_stb, ick_tick;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    scl_clk_gen u0 (
        .clk         (clk),
        .rst         (rst),
        .run_i       (run),
        .cfg_wr_i    (cfg_wr),
        .cfg_word_i  (cfg_word),
        .lat_i       (lat),
        .scl_sense_i (sense),
        .scl_low_o   (scl_low),
        .fall_stb_o  (fall_stb),
        .rise_stb_o  (rise_stb),
        .ick_tick_o  (ick_tick)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=190000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int per_ticks(int g, int l);
        return 20 + 8 * g + l;
    endfunction
    function automatic int exp_low(int g, int c, int l);
        return (per_ticks(g, l) / 2) * (c + 1);
    endfunction
    function automatic int exp_high(int g, int c, int l);
        return (per_ticks(g, l) - per_ticks(g, l) / 2) * (c + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_now(input int g, input int c);
        cfg_wr   = 1'b1;
        cfg_word = {g[5:0], c[PW-1:0]};
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    task automatic start(input int g, input int c, input int l);
        run = 1'b0;
        @(negedge clk);
        write_now(g, c);
        lat = l[LW-1:0];
        run = 1'b1;
        @(negedge clk);
        check(scl_low && fall_stb, "R5 start", {30'd0, scl_low, fall_stb}, 3);
    endtask

    // measures one period from a fall strobe; returns at the next fall strobe
    task automatic measure(output int lo, output int hi, output bit rise_ok);
        lo = 0; hi = 0; rise_ok = 1'b0;
        while (!fall_stb) @(negedge clk);
        while (scl_low) begin lo++; @(negedge clk); end
        rise_ok = rise_stb;
        while (!fall_stb) begin hi++; @(negedge clk); end
    endtask

    task automatic check_period(input int g, input int c, input int l, input string req);
        int lo, hi;
        bit rok;
        measure(lo, hi, rok);
        check(lo == exp_low(g, c, l), req, lo, exp_low(g, c, l));
        check(hi == exp_high(g, c, l), req, hi, exp_high(g, c, l));
        check(rok, "R5 rise strobe", int'(rok), 1);
    endtask

    initial begin
        int lo, hi, cnt, g, c, l, k, pulses;
        bit rok;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!scl_low && !fall_stb && !rise_stb && !ick_tick, "R1 reset outputs",
              {28'd0, scl_low, fall_stb, rise_stb, ick_tick}, 0);

        // R1: reset configuration gives N=20, d=0 when run starts with no write
        run = 1'b1;
        check_period(0, 0, 0, "R1 reset config");

        // R4 odd count: N=21 splits 10/11
        start(0, 0, 1);
        check_period(0, 0, 1, "R4 odd split");

        // R4 / R2 largest setting: gear 63, pre-divide 7, latency 15
        start(63, 7, 15);
        check_period(63, 7, 15, "R4 max setting");

        // R2 field placement: gear 5 in bits [8:3], pre-divide 2 in bits [2:0]
        start(5, 2, 3);
        check_period(5, 2, 3, "R2 decode");

        // R3 tick spacing with pre-divide 5
        start(1, 5, 0);
        while (!ick_tick) @(negedge clk);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!ick_tick);
        check(cnt == 6, "R3 tick spacing", cnt, 6);

        // R6 stretch by K cycles in the high phase
        start(2, 1, 2);
        k = 13;
        while (!rise_stb) @(negedge clk);
        sense = 1'b0;
        cnt = 0;
        repeat (k) begin @(negedge clk); cnt++; end
        sense = 1'b1;
        while (!fall_stb) begin @(negedge clk); cnt++; end
        check(cnt == exp_high(2, 1, 2) + k, "R6 stretch", cnt, exp_high(2, 1, 2) + k);

        // R7 sense low through a whole low phase
        lo = 0;
        sense = 1'b0;
        while (scl_low) begin lo++; @(negedge clk); end
        sense = 1'b1;
        check(lo == exp_low(2, 1, 2), "R7 sense ignored in low", lo, exp_low(2, 1, 2));

        // R8 write mid-period: current period keeps old length
        start(3, 1, 0);
        check_period(3, 1, 0, "R8 before write");
        write_now(9, 0);
        cnt = 1;
        while (!fall_stb) begin @(negedge clk); cnt++; end
        check(cnt == exp_low(3, 1, 0) + exp_high(3, 1, 0), "R8 old period kept",
              cnt, exp_low(3, 1, 0) + exp_high(3, 1, 0));
        check_period(9, 0, 0, "R8 new period");
        // R8 last of two writes wins
        write_now(4, 3);
        write_now(7, 2);
        while (!fall_stb) @(negedge clk);
        check_period(7, 2, 0, "R8 last write wins");

        // R10 latency change mid-period
        start(2, 1, 3);
        check_period(2, 1, 3, "R10 before change");
        lat = 4'd9;
        @(negedge clk);
        cnt = 1;
        while (!fall_stb) begin @(negedge clk); cnt++; end
        check(cnt == exp_low(2, 1, 3) + exp_high(2, 1, 3), "R10 old latency kept",
              cnt, exp_low(2, 1, 3) + exp_high(2, 1, 3));
        check_period(2, 1, 9, "R10 new latency");

        // R9 stop mid low phase, stay idle, restart with idle write
        repeat (5) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check(!scl_low, "R9 released after stop", int'(scl_low), 0);
        pulses = 0;
        repeat (30) begin
            @(negedge clk);
            pulses += int'(fall_stb) + int'(rise_stb) + int'(ick_tick) + int'(scl_low);
        end
        check(pulses == 0, "R9 quiet while idle", pulses, 0);
        write_now(6, 4);
        lat = 4'd2;
        run = 1'b1;
        check_period(6, 4, 2, "R9 restart config");

        // random settings
        for (int i = 0; i < 8; i++) begin
            g = $urandom_range(0, 63);
            c = $urandom_range(0, 7);
            l = $urandom_range(0, 15);
            start(g, c, l);
            check_period(g, c, l, "R4 random");
        end

        run = 1'b0;
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule